// File: doc/BRIEF.md
# Stall-Go Link Flow Control

This block guards one link between a sending router and the input FIFO of the router downstream. It keeps a count of the free slots in that FIFO. The count drops when a flit is launched and rises when the receiver pops a flit. From this count it derives a three-level link status: Go, Sent or Stop. The sender uses the status to decide, each cycle, whether a flit may be launched. A flit therefore can never arrive at a full FIFO, and the receiver never has to look for dropped flits.

On the upstream side, flits are offered through a valid/ready handshake. `in_ready_o` depends only on registered state and never on `in_valid_i`. A flit is launched in every cycle where both `in_valid_i` and `in_ready_o` are high. A launched flit is presented to the downstream FIFO in the same cycle as a push (`out_valid_o`, `out_data_o`). The downstream FIFO has no ready signal, because back-pressure comes only through the status. Stop has a special rule: it can only be left for Go, never for Sent. Each entry into Stop raises a low-priority flag that tells the upstream arbiter to deprioritise this port.

Top module: `stallgo_link`

## Requirements
- R1: After reset the status is Go (encoding 2'b00), `in_ready_o` is high, `low_prio_o` is low and all DEPTH slots are free.
- R2: The status is Go (2'b00) exactly when at least two slots are free, except while it is held in Stop (see R6).
- R3: A flit is never launched when no slot is free, so at most DEPTH flits are outstanding between launches and pops.
- R4: The status is Sent (2'b01) when exactly one slot is free and the status was Go or Sent in the previous cycle.
- R5: The status is Stop (2'b10) when no slot is free, and `in_ready_o` is low while the status is Stop.
- R6: From Stop the status goes only to Go, once at least two slots are free. With one free slot it stays in Stop.
- R7: A launch takes one free slot, a pop returns one, and a launch and a pop in the same cycle leave the count unchanged. The status reflects the new count in the cycle after the event.
- R8: A pop while all DEPTH slots are free is ignored, including when a launch happens in the same cycle.
- R9: In Sent, at most one flit is launched. After that flit, `in_ready_o` stays low until the status leaves Sent.
- R10: `low_prio_o` rises in the cycle the status enters Stop. It falls after the next launched flit, and if both happen in the same cycle, entering Stop wins.
- R11: `out_valid_o` equals `in_valid_i && in_ready_o`, and `out_data_o` carries `in_data_i` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Upstream flit offered |
| in_ready_o | output | 1 | Launch permitted this cycle |
| in_data_i | input | FLIT_W | Upstream flit |
| out_valid_o | output | 1 | Push into downstream FIFO |
| out_data_o | output | FLIT_W | Flit pushed downstream |
| pop_i | input | 1 | Downstream FIFO released one flit |
| link_state_o | output | 2 | Status: 00 Go, 01 Sent, 10 Stop |
| low_prio_o | output | 1 | Port demoted at upstream arbiter |

## Verification
The hardest situation to reach is Stop with exactly one free slot. The link has to be filled completely and then drained by a single pop, which is where a wrong Stop-to-Sent move would show. A second hard case is Sent with a launch and a pop in the same cycle: the count stays at one, but the sender must hold off. The stimulus drives both cases directly and then sweeps long pseudo-random valid/pop streams at several densities on a depth-4 link, so that every count and state pair is visited many times.

// File: rtl/stallgo_pkg.sv
package stallgo_pkg;
  typedef enum logic [1:0] {
    LS_GO   = 2'b00,
    LS_SENT = 2'b01,
    LS_STOP = 2'b10
  } link_state_e;
endpackage

// File: rtl/stallgo_slot_ctr.sv
module stallgo_slot_ctr #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] free_q_o,
  output logic [CNT_W-1:0] free_d_o
);
  localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);

  logic [CNT_W-1:0] free_q;
  logic             pop_eff;

  // a pop on an already-empty FIFO is meaningless and dropped
  assign pop_eff = pop_i && (free_q != FULL_FREE);

  always_comb begin
    free_d_o = free_q;
    unique case ({launch_i, pop_eff})
      2'b10:   free_d_o = free_q - 1'b1;
      2'b01:   free_d_o = free_q + 1'b1;
      default: free_d_o = free_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) free_q <= FULL_FREE;
    else         free_q <= free_d_o;
  end

  assign free_q_o = free_q;
endmodule

// File: rtl/stallgo_status_fsm.sv
module stallgo_status_fsm
  import stallgo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] free_d_i,
  output link_state_e      state_q_o,
  output link_state_e      state_d_o
);
  link_state_e state_q;
  logic        room_many, room_one;

  assign room_many = free_d_i >= CNT_W'(2);
  assign room_one  = free_d_i == CNT_W'(1);

  always_comb begin
    state_d_o = state_q;
    unique case (state_q)
      LS_GO, LS_SENT: begin
        if (room_many)     state_d_o = LS_GO;
        else if (room_one) state_d_o = LS_SENT;
        else               state_d_o = LS_STOP;
      end
      LS_STOP: begin
        // only a return to full Go is allowed
        if (room_many) state_d_o = LS_GO;
        else           state_d_o = LS_STOP;
      end
      default: state_d_o = LS_STOP;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= LS_GO;
    else         state_q <= state_d_o;
  end

  assign state_q_o = state_q;
endmodule

// File: rtl/stallgo_send_gate.sv
module stallgo_send_gate
  import stallgo_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  link_state_e state_q_i,
  input  link_state_e state_d_i,
  output logic        ready_o,
  output logic        launch_o,
  output logic        low_prio_o
);
  logic hold_q, low_q;
  logic sent_shot, enter_stop;

  assign ready_o    = (state_q_i == LS_GO) || ((state_q_i == LS_SENT) && !hold_q);
  assign launch_o   = valid_i && ready_o;
  assign sent_shot  = launch_o && (state_q_i == LS_SENT);
  assign enter_stop = (state_d_i == LS_STOP) && (state_q_i != LS_STOP);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      low_q  <= 1'b0;
    end else begin
      hold_q <= (state_d_i == LS_SENT) && (hold_q || sent_shot);
      if (enter_stop)    low_q <= 1'b1;
      else if (launch_o) low_q <= 1'b0;
    end
  end

  assign low_prio_o = low_q;
endmodule

// File: rtl/stallgo_link.sv
module stallgo_link
  import stallgo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int FLIT_W = 20,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [FLIT_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [FLIT_W-1:0] out_data_o,
  input  logic              pop_i,
  output logic [1:0]        link_state_o,
  output logic              low_prio_o
);
  logic [CNT_W-1:0] free_cnt, free_nxt;
  link_state_e      state_q, state_d;
  logic             launch;

  stallgo_slot_ctr #(.DEPTH(DEPTH)) ctr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .pop_i    (pop_i),
    .free_q_o (free_cnt),
    .free_d_o (free_nxt)
  );

  stallgo_status_fsm #(.DEPTH(DEPTH)) fsm_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .free_d_i  (free_nxt),
    .state_q_o (state_q),
    .state_d_o (state_d)
  );

  stallgo_send_gate gate_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (in_valid_i),
    .state_q_i  (state_q),
    .state_d_i  (state_d),
    .ready_o    (in_ready_o),
    .launch_o   (launch),
    .low_prio_o (low_prio_o)
  );

  assign out_valid_o  = launch;
  assign out_data_o   = in_data_i;
  assign link_state_o = state_q;
endmodule

// File: rtl/stallgo_link_chk.sv
module stallgo_link_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             pop_i,
  input logic [1:0]       link_state_o,
  input logic             low_prio_o,
  input logic [CNT_W-1:0] free_cnt
);
  p_go_room_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_state_o == 2'b00 |-> free_cnt >= CNT_W'(2));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> free_cnt != '0);
  p_sent_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_state_o == 2'b01 |-> free_cnt == CNT_W'(1));
  p_stop_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_state_o == 2'b10 |-> !in_ready_o);
  p_no_stop_to_sent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_state_o == 2'b10 |=> link_state_o != 2'b01);
  p_count_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !pop_i) |=> free_cnt == $past(free_cnt) - 1'b1);
  p_empty_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !out_valid_o && free_cnt == CNT_W'(DEPTH)) |=> free_cnt == CNT_W'(DEPTH));
  p_sent_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == 2'b01 && out_valid_o) |=> !in_ready_o);
  p_lowprio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_state_o == 2'b10) |-> low_prio_o);
  p_handshake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> in_valid_i);
endmodule

bind stallgo_link stallgo_link_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .pop_i        (pop_i),
  .link_state_o (link_state_o),
  .low_prio_o   (low_prio_o),
  .free_cnt     (free_cnt)
);

// File: tb/stallgo_link_tb_top.sv
`timescale 1ns/1ps
module stallgo_link_tb_top;
  localparam int DEPTH  = 4;
  localparam int FLIT_W = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [FLIT_W-1:0] in_data = '0;
  logic              out_valid;
  logic [FLIT_W-1:0] out_data;
  logic              pop = 1'b0;
  logic [1:0]        lstate;
  logic              low_prio;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // model state
  int m_free = DEPTH;
  int m_st   = 0;
  bit m_hold = 0;
  bit m_low  = 0;
  int unsigned lfsr = 32'h1F2E3D4C;

  always #2 clk = ~clk;

  stallgo_link #(.DEPTH(DEPTH), .FLIT_W(FLIT_W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .in_valid_i   (in_valid),
    .in_ready_o   (in_ready),
    .in_data_i    (in_data),
    .out_valid_o  (out_valid),
    .out_data_o   (out_data),
    .pop_i        (pop),
    .link_state_o (lstate),
    .low_prio_o   (low_prio)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string st_tag(input int s);
    if (s == 0) return "R2 status";
    if (s == 1) return "R4 status";
    return "R5 status";
  endfunction

  // apply one cycle of stimulus, compare, advance the model
  task automatic step(input bit v, input bit p);
    int  rdy, launch, popeff, nfree, nst;
    bit  nlow;
    @(negedge clk);
    in_valid = v;
    pop      = p;
    in_data  = FLIT_W'(lfsr);
    #1;
    rdy    = (m_st == 0) || (m_st == 1 && !m_hold);
    launch = v && rdy;
    chk(st_tag(m_st), int'(lstate), m_st);
    chk(m_st == 1 ? "R9 ready" : "R3 ready", int'(in_ready), rdy);
    chk("R10 low_prio", int'(low_prio), int'(m_low));
    chk("R11 out_valid", int'(out_valid), launch);
    if (launch) chk("R11 out_data", int'(out_data), int'(in_data));
    popeff = (p && m_free < DEPTH) ? 1 : 0;
    nfree  = m_free - launch + popeff;
    if (m_st == 2) nst = (nfree >= 2) ? 0 : 2;
    else           nst = (nfree >= 2) ? 0 : (nfree == 1 ? 1 : 2);
    if (nst == 2 && m_st != 2) nlow = 1;
    else if (launch)           nlow = 0;
    else                       nlow = m_low;
    m_hold = (nst == 1) && (m_hold || (m_st == 1 && launch));
    m_low  = nlow;
    m_free = nfree;
    m_st   = nst;
    lfsr   = lfsr * 32'd1664525 + 32'd1013904223;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 status", int'(lstate), 0);
    chk("R1 ready", int'(in_ready), 1);
    chk("R1 low_prio", int'(low_prio), 0);

    // R8: pops on an empty FIFO change nothing
    repeat (3) step(0, 1);
    step(1, 1);                  // launch with ignored pop: free 3
    // fill the rest: free 2 (Go), 1 (Sent), then launch in Sent -> 0 (Stop)
    step(1, 0); step(1, 0); step(1, 0);
    @(negedge clk); #1;
    chk("R8 reached Stop after DEPTH launches", int'(lstate), 2);
    chk("R10 demoted on Stop", int'(low_prio), 1);
    // R6: one pop in Stop leaves one slot, status must hold Stop
    step(1, 1);
    step(1, 0);
    @(negedge clk); #1;
    chk("R6 stays Stop with one slot", int'(lstate), 2);
    step(0, 1);
    step(0, 0);
    @(negedge clk); #1;
    chk("R6 Stop leaves to Go", int'(lstate), 0);
    // R7: simultaneous launch and pop keeps Go
    repeat (4) step(1, 1);
    @(negedge clk); #1;
    chk("R7 balanced traffic keeps Go", int'(lstate), 0);
    // R9: reach Sent, then launch with a pop in the same cycle
    step(1, 0);                  // free 1 -> Sent
    step(1, 1);                  // launch in Sent, pop too: free stays 1
    step(1, 0);                  // must be held off
    step(1, 0);
    step(0, 1);                  // pop -> free 2 -> Go
    step(1, 0);

    // near-exhaustive sweep at several densities
    for (int dens = 0; dens < 4; dens++) begin
      for (int n = 0; n < 3000; n++) begin
        int unsigned r = lfsr >> 8;
        bit vv = ((r & 32'h7) <= (32'(dens) * 2 + 1));
        bit pp = (((r >> 4) & 32'h7) <= (32'(3 - dens) * 2 + 1));
        step(vv, pp);
      end
    end
    repeat (8) step(0, 1);
    @(negedge clk); #1;
    chk("R2 drained link back to Go", int'(lstate), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule